// File: doc/BRIEF.md
# Split Block/Page Encryption Counter Manager

This block holds the write counters that seed one-time-pad generation for counter-mode memory encryption. It covers a single page of 64 blocks. Each block has a narrow 7-bit counter, and the whole page shares one wide 64-bit counter. A block's pad seed is the page counter followed by that block's counter. The 64 block counters plus the page counter occupy exactly 512 bits.

A block-write event carries a block index and bumps that block's counter. A write cannot simply wrap a counter that is already at its maximum. Instead the write is held and the page counter moves up by one. The block then walks the page in ascending index order. For each block it issues one command to read, decrypt under the old seed, re-encrypt under the new seed and write back. It waits for an acknowledgement of each command, and each acknowledgement resets that block's counter. When the last acknowledgement arrives the walk ends, and the held write is accepted against the fresh counter. Seed queries stay available throughout the walk.

Top module: `ctr_page_mgr`

## Requirements
- R1: After reset every block counter and the page counter are zero, `busy` and `cmdValid` are low, `qryRspValid` is low and `wrReady` is high.
- R2: A write accepted (`wrValid` and `wrReady` high at a clock edge) adds one to the counter of block `wrIdx` and leaves every other counter unchanged.
- R3: A seed is 71 bits wide. Bits [70:7] carry the page counter and bits [6:0] carry the block counter.
- R4: `qryValid` at a clock edge gives `qryRspValid` high one cycle later. `qrySeed` then holds the seed of `qryIdx` as it stood before that edge.
- R5: A write to a block whose counter is 127 sees `wrReady` low. At that edge a walk starts and `busy` rises; no block counter ever wraps.
- R6: During a walk, `cmdValid` is high and `cmdIdx` steps through 0 to 63 in order. Each index is held until a cycle with `cmdAck` high. `cmdOldSeed` is {page, counter of `cmdIdx`} and `cmdNewSeed` is {page+1, 0}.
- R7: While `busy` is high, `wrReady` is low for every index.
- R8: The acknowledgement of block 63 adds one to the page counter, leaves all block counters at zero and drops `busy`. A held write is then accepted, and its block counter reads 1.
- R9: A query during a walk returns {page+1, 0} for a block whose index is below `cmdIdx`. For any other block it returns the old seed {page, counter}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Block-write event offered |
| wrIdx | input | 6 | Index of the written block |
| wrReady | output | 1 | Write event accepted this cycle |
| qryValid | input | 1 | Seed query request |
| qryIdx | input | 6 | Block whose seed is queried |
| qryRspValid | output | 1 | Seed response valid |
| qrySeed | output | 71 | Pad seed {page, block} |
| cmdValid | output | 1 | Re-encryption command pending |
| cmdIdx | output | 6 | Block to re-encrypt |
| cmdOldSeed | output | 71 | Seed to decrypt with |
| cmdNewSeed | output | 71 | Seed to re-encrypt with |
| cmdAck | input | 1 | Current command completed |
| busy | output | 1 | Page re-encryption walk in progress |

## Verification
`wrReady` is combinational, so the bench reads it a moment after driving a write and before the accepting edge. The counter change lands at that edge, so a query issued in the following cycle already sees it. A query response is due one edge after the request, and the monitor samples it at the next falling edge. The command index moves one edge after an acknowledgement. The page increment, the clearing of `busy` and the release of the held write all show right after the final acknowledgement edge. Each check is placed at exactly those points.

// File: rtl/ctr_mgr_pkg.sv
package ctr_mgr_pkg;
  // strobes from the walk controller to the counter store
  typedef struct packed {
    logic bumpBlk;   // accepted write: increment counter at wrIdx
    logic clearBlk;  // acknowledged rewrite: clear counter at walkIdx
    logic bumpPage;  // final acknowledgement: advance page counter
  } ctr_strobe_t;
endpackage

// File: rtl/ctr_walk_ctrl.sv
module ctr_walk_ctrl
  import ctr_mgr_pkg::*;
#(
  parameter int NUM_BLOCKS = 64,
  parameter int IDX_W      = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             atMax,
  input  logic             cmdAck,
  output logic             wrReady,
  output logic             busy,
  output logic [IDX_W-1:0] walkIdx,
  output ctr_strobe_t      strobe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLOCKS - 1);

  logic             busyQ;
  logic [IDX_W-1:0] ptrQ;
  logic             startWalk;
  logic             stepWalk;

  assign wrReady   = !busyQ && !(wrValid && atMax);
  assign startWalk = wrValid && atMax && !busyQ;
  assign stepWalk  = busyQ && cmdAck;

  always_comb begin
    strobe          = '0;
    strobe.bumpBlk  = wrValid && wrReady;
    strobe.clearBlk = stepWalk;
    strobe.bumpPage = stepWalk && (ptrQ == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      ptrQ  <= '0;
    end else if (startWalk) begin
      busyQ <= 1'b1;
      ptrQ  <= '0;
    end else if (stepWalk) begin
      if (ptrQ == LAST_IDX) busyQ <= 1'b0;
      else                  ptrQ  <= ptrQ + IDX_W'(1);
    end
  end

  assign busy    = busyQ;
  assign walkIdx = ptrQ;

  // R6: the walk advances by exactly one index per acknowledgement
  a_r6_ascending: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && cmdAck && ptrQ != LAST_IDX) |=> (busyQ && ptrQ == $past(ptrQ) + IDX_W'(1)));

  // R6: an unacknowledged command holds its index
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !cmdAck) |=> (busyQ && $stable(ptrQ)));
endmodule

// File: rtl/ctr_store_dp.sv
module ctr_store_dp
  import ctr_mgr_pkg::*;
#(
  parameter int NUM_BLOCKS = 64,
  parameter int BLK_W      = 7,
  parameter int PAGE_W     = 64,
  parameter int IDX_W      = 6,
  parameter int SEED_W     = 71
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctr_strobe_t       strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  walkIdx,
  input  logic              busy,
  input  logic              qryValid,
  input  logic [IDX_W-1:0]  qryIdx,
  output logic              atMax,
  output logic              qryRspValid,
  output logic [SEED_W-1:0] qrySeed,
  output logic [SEED_W-1:0] cmdOldSeed,
  output logic [SEED_W-1:0] cmdNewSeed
);
  localparam logic [BLK_W-1:0] BLK_MAX = {BLK_W{1'b1}};

  logic [BLK_W-1:0]  blkCtr [NUM_BLOCKS];
  logic [PAGE_W-1:0] pageQ;
  logic [PAGE_W-1:0] pageNext;

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
    logic incHere;
    logic clrHere;
    assign incHere = strobe.bumpBlk  && (wrIdx   == IDX_W'(g));
    assign clrHere = strobe.clearBlk && (walkIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN)        blkCtr[g] <= '0;
      else if (clrHere) blkCtr[g] <= '0;
      else if (incHere) blkCtr[g] <= blkCtr[g] + BLK_W'(1);
    end

    // R5: the controller never increments a saturated counter
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
      incHere |-> (blkCtr[g] != BLK_MAX));

    // R8: every counter is zero once the walk ends
    a_r8_cleared: assert property (@(posedge clk) disable iff (!rstN)
      $fell(busy) |-> (blkCtr[g] == '0));
  end

  always_ff @(posedge clk) begin
    if (!rstN)                pageQ <= '0;
    else if (strobe.bumpPage) pageQ <= pageNext;
  end

  assign pageNext   = pageQ + PAGE_W'(1);
  assign atMax      = (blkCtr[wrIdx] == BLK_MAX);
  assign cmdOldSeed = {pageQ, blkCtr[walkIdx]};
  assign cmdNewSeed = {pageNext, BLK_W'(0)};

  logic              qryDone;
  logic [PAGE_W-1:0] qryPage;
  logic [SEED_W-1:0] seedQ;
  logic              rspQ;

  assign qryDone = busy && (qryIdx < walkIdx);
  assign qryPage = qryDone ? pageNext : pageQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspQ  <= 1'b0;
      seedQ <= '0;
    end else begin
      rspQ <= qryValid;
      if (qryValid) seedQ <= {qryPage, blkCtr[qryIdx]};
    end
  end

  assign qryRspValid = rspQ;
  assign qrySeed     = seedQ;

  // R8: the page counter only ever steps up by one
  a_r8_page_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pageQ) |-> (pageQ == $past(pageQ) + PAGE_W'(1)));
endmodule

// File: rtl/ctr_page_mgr.sv
module ctr_page_mgr
  import ctr_mgr_pkg::*;
#(
  parameter int NUM_BLOCKS = 64,
  parameter int BLK_W      = 7,
  parameter int PAGE_W     = 64,
  localparam int IDX_W     = $clog2(NUM_BLOCKS),
  localparam int SEED_W    = PAGE_W + BLK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [IDX_W-1:0]  wrIdx,
  output logic              wrReady,
  input  logic              qryValid,
  input  logic [IDX_W-1:0]  qryIdx,
  output logic              qryRspValid,
  output logic [SEED_W-1:0] qrySeed,
  output logic              cmdValid,
  output logic [IDX_W-1:0]  cmdIdx,
  output logic [SEED_W-1:0] cmdOldSeed,
  output logic [SEED_W-1:0] cmdNewSeed,
  input  logic              cmdAck,
  output logic              busy
);
  ctr_strobe_t      strobe;
  logic             atMax;
  logic             busyInt;
  logic [IDX_W-1:0] walkIdx;

  ctr_walk_ctrl #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .atMax(atMax), .cmdAck(cmdAck),
    .wrReady(wrReady), .busy(busyInt), .walkIdx(walkIdx), .strobe(strobe)
  );

  ctr_store_dp #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W), .PAGE_W(PAGE_W),
                 .IDX_W(IDX_W), .SEED_W(SEED_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .walkIdx(walkIdx),
    .busy(busyInt), .qryValid(qryValid), .qryIdx(qryIdx), .atMax(atMax),
    .qryRspValid(qryRspValid), .qrySeed(qrySeed),
    .cmdOldSeed(cmdOldSeed), .cmdNewSeed(cmdNewSeed)
  );

  assign busy     = busyInt;
  assign cmdValid = busyInt;
  assign cmdIdx   = walkIdx;
endmodule

// File: tb/ctr_page_mgr_tb.sv
module ctr_page_mgr_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [5:0]  wrIdx = '0;
  logic        wrReady;
  logic        qryValid = 1'b0;
  logic [5:0]  qryIdx = '0;
  logic        qryRspValid;
  logic [70:0] qrySeed;
  logic        cmdValid;
  logic [5:0]  cmdIdx;
  logic [70:0] cmdOldSeed;
  logic [70:0] cmdNewSeed;
  logic        cmdAck = 1'b0;
  logic        busy;

  always #10 clk = ~clk;  // 50 MHz

  ctr_page_mgr u_dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrIdx(wrIdx), .wrReady(wrReady),
    .qryValid(qryValid), .qryIdx(qryIdx), .qryRspValid(qryRspValid), .qrySeed(qrySeed),
    .cmdValid(cmdValid), .cmdIdx(cmdIdx), .cmdOldSeed(cmdOldSeed), .cmdNewSeed(cmdNewSeed),
    .cmdAck(cmdAck), .busy(busy)
  );

  int checkCnt = 0;
  int failCnt  = 0;

  // reference model
  logic [6:0]  refCtr [64];
  logic [63:0] refPage = '0;
  bit          refBusy = 1'b0;
  int          refPos  = 0;

  logic [70:0] expQ[$];
  string       tagQ[$];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [70:0] expSeed(input int idx);
    logic [63:0] pg;
    pg = (refBusy && idx < refPos) ? refPage + 64'd1 : refPage;
    return {pg, refCtr[idx]};
  endfunction

  task automatic doWrite(input int idx);
    @(negedge clk);
    wrValid = 1'b1;
    wrIdx   = 6'(idx);
    #1 chk(wrReady == 1'b1, "R2 write accepted", 128'(wrReady), 128'd1);
    @(posedge clk);
    #1 wrValid = 1'b0;
    refCtr[idx] = refCtr[idx] + 7'd1;
  endtask

  task automatic doQuery(input int idx, input string tag);
    @(negedge clk);
    qryValid = 1'b1;
    qryIdx   = 6'(idx);
    expQ.push_back(expSeed(idx));
    tagQ.push_back(tag);
    @(posedge clk);
    #1 qryValid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && qryRspValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R4 unexpected response", 128'(qrySeed), 128'd0);
      end else begin
        logic [70:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(qrySeed == e, t, 128'(qrySeed), 128'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) refCtr[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", 128'(busy), 128'd0);
    chk(cmdValid == 1'b0, "R1 cmdValid", 128'(cmdValid), 128'd0);
    chk(qryRspValid == 1'b0, "R1 qryRspValid", 128'(qryRspValid), 128'd0);
    chk(wrReady == 1'b1, "R1 wrReady", 128'(wrReady), 128'd1);
    doQuery(0, "R1 block 0 seed");
    doQuery(63, "R1 block 63 seed");

    // R2/R3 counting and seed layout
    repeat (5) doWrite(3);
    repeat (2) doWrite(40);
    doWrite(63);
    doQuery(3, "R3 block 3 seed");
    doQuery(40, "R2 block 40 seed");
    doQuery(63, "R2 block 63 seed");
    doQuery(0, "R2 untouched block 0");

    // R4 query in the cycle right after a write
    doWrite(3);
    doQuery(3, "R4 query after write");

    // drive block 9 to its limit
    repeat (127) doWrite(9);
    doQuery(9, "R3 block 9 at limit");

    // R5 overflowing write is held and starts the walk
    @(negedge clk);
    wrValid = 1'b1;
    wrIdx   = 6'd9;
    #1 chk(wrReady == 1'b0, "R5 held at limit", 128'(wrReady), 128'd0);
    @(posedge clk);
    #1 chk(busy == 1'b1, "R5 busy raised", 128'(busy), 128'd1);
    refBusy = 1'b1;
    refPos  = 0;

    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      chk(cmdValid && cmdIdx == 6'(i), "R6 command index", 128'(cmdIdx), 128'(i));
      chk(cmdOldSeed == {refPage, refCtr[i]}, "R6 old seed", 128'(cmdOldSeed), 128'({refPage, refCtr[i]}));
      chk(cmdNewSeed == {refPage + 64'd1, 7'd0}, "R6 new seed", 128'(cmdNewSeed), 128'({refPage + 64'd1, 7'd0}));
      if (i == 4) begin
        repeat (2) @(negedge clk);
        chk(cmdValid && cmdIdx == 6'd4, "R6 hold without ack", 128'(cmdIdx), 128'd4);
      end
      if (i == 10) begin
        doQuery(5, "R9 rewritten block");
        doQuery(20, "R9 pending block");
        doQuery(10, "R9 current block");
      end
      if (i == 30) begin
        wrIdx = 6'd63;
        #1 chk(wrReady == 1'b0, "R7 other block held", 128'(wrReady), 128'd0);
        wrIdx = 6'd9;
      end
      #1 chk(wrReady == 1'b0, "R7 held during walk", 128'(wrReady), 128'd0);
      cmdAck = 1'b1;
      @(posedge clk);
      #1 cmdAck = 1'b0;
      refCtr[i] = '0;
      refPos    = i + 1;
    end

    // R8 completion
    refPage = refPage + 64'd1;
    refBusy = 1'b0;
    chk(busy == 1'b0, "R8 busy cleared", 128'(busy), 128'd0);
    chk(cmdValid == 1'b0, "R8 no command", 128'(cmdValid), 128'd0);
    chk(wrReady == 1'b1, "R8 held write released", 128'(wrReady), 128'd1);
    @(posedge clk);
    #1 wrValid = 1'b0;
    refCtr[9] = 7'd1;
    doQuery(9, "R8 block 9 after release");
    doQuery(3, "R8 block 3 reset");
    doQuery(63, "R8 block 63 reset");
    doQuery(40, "R8 block 40 reset");
    doWrite(3);
    doQuery(3, "R2 write after walk");

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R4 all responses seen", 128'(expQ.size()), 128'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule